// File: doc/BRIEF.md
# Indexed Block-Access SMBus Register Target

This block is a slave-only two-wire serial target that gives a host access to a small bank of eight-bit configuration registers. Every transfer names a starting register offset. A write then gives a byte count, followed by that many data bytes. The bytes land at consecutive offsets, starting at the named one. A read returns the size of the register bank first, and then data from consecutive offsets until the host declines a byte.

SCL and SDA are sampled with the system clock. Each line passes through a two-flop synchronizer and a filter that accepts a new level only after two equal samples. Edge detection works on the filtered levels. START, repeated START and STOP are found from SDA edges seen while SCL is high. The block pulls SDA low through an open-drain enable and never stretches the clock.

Toward the chip, the block puts out a write strobe with an index and raw data for each accepted data byte. It also puts out the two writable control registers. One read-only register reflects an identification input.

Top module: `smb_idx_slave`

## Requirements
- R1: Address byte D4h (write) and D5h (read), which is 7-bit address 1101010, is acknowledged with SDA low. Any other address byte is not acknowledged, and SDA stays released until the next START or STOP.
- R2: A write has the form address D4h, offset N, count X, then data. Each of these bytes is acknowledged, and data byte k (counting from 0) is stored at offset N+k.
- R3: Data bytes after the X counted ones are not acknowledged (SDA high in the ack slot) and change no register.
- R4: After an offset has been written, a repeated START and D5h make the target send the bank size 07h first. It then sends bytes from offset N, N+1, and so on. Each byte goes most significant bit first, and the offset is kept across the repeated START.
- R5: When the host answers a read byte with NACK (SDA high), the target sends nothing more and leaves SDA released.
- R6: After reset, SDA is released, register 0 (`ctl_main`) is 02h and register 1 (`ctl_aux`) is 04h.
- R7: In register 1 only bit 2 can be written; its other bits read 0. Registers 2 to 5 always read 00h. Register 6 always reads `id_code`. Writes to read-only bits have no effect.
- R8: Offsets 07h and above read as 00h, and writes to them are discarded.
- R9: A START or STOP in the middle of a byte aborts the transfer. SDA is released, no register changes, and the next transfer starts cleanly.
- R10: SDA driven by the target changes only after a filtered SCL falling edge (or a START/STOP release), so it is stable while SCL is high.
- R11: Each data byte accepted within the count gives a one-cycle `wr_stb` with `wr_idx` = target offset and `wr_data` = received byte, issued while SCL is low.
- R12: A pulse on SCL lasting one system-clock cycle is filtered out and does not add a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low (open drain) |
| id_code | input | 8 | Value returned by read-only register 6 |
| ctl_main | output | 8 | Register 0 contents |
| ctl_aux | output | 8 | Register 1 contents (only bit 2 writable) |
| wr_stb | output | 1 | One-cycle pulse per accepted data byte |
| wr_idx | output | 8 | Offset of the accepted byte |
| wr_data | output | 8 | Raw data of the accepted byte |

## Verification
The assertions take for granted that the host changes SDA only while SCL is low, except for deliberate START and STOP conditions. They also assume the host never moves SCL and SDA within the same few sampling cycles, because simultaneous edges would make a START or STOP ambiguous. The stimulus keeps a whole half-bit of SCL-low time around every SDA change and runs the bit period far slower than the filter latency. Its only glitch is a single-cycle SCL pulse placed while SDA is stable.

// File: rtl/smb_pkg.sv
// Shared types for the indexed block-access serial target.
// Assumes: one byte engine, phases visited in protocol order.
package smb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for START
        PH_ADDR,   // receiving address byte
        PH_OFFS,   // receiving register offset
        PH_CNT,    // receiving byte count
        PH_WDATA,  // receiving data bytes
        PH_TX,     // sending count then data
        PH_SKIP    // released until START or STOP
    } phase_t;

endpackage

// File: rtl/smb_deglitch.sv
// Line conditioner: multi-flop synchronizer, then a filter that accepts a new
// level only after two equal samples, then edge pulses on the filtered level.
// Assumes: idle bus level is high; STAGES >= 2.
module smb_deglitch #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              samp_d;
    logic              lvl_d;

    // Synchronize, filter and delay the line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            samp_d <= 1'b1;
            level  <= 1'b1;
            lvl_d  <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], raw};
            samp_d <= sync_q[STAGES-1];
            if (sync_q[STAGES-1] == samp_d)
                level <= samp_d;
            lvl_d  <= level;
        end
    end

    assign rise = level & ~lvl_d;
    assign fall = ~level & lvl_d;

endmodule

// File: rtl/smb_regbank.sv
// Register bank: NREG byte registers with per-register write masks.
// Register 0 fully writable, register 1 writable in AUX_MASK bits, register
// ID_IDX returns id_code, all others read zero. Out-of-range reads give 00h.
// Assumes: wr_stb is a single-cycle pulse.
module smb_regbank #(
    parameter int          NREG     = 7,
    parameter int          ID_IDX   = 6,
    parameter logic [7:0]  MAIN_RST = 8'h02,
    parameter logic [7:0]  AUX_RST  = 8'h04,
    parameter logic [7:0]  AUX_MASK = 8'h04
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [7:0] id_code,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data,
    output logic [7:0] ctl_main,
    output logic [7:0] ctl_aux
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [7:0] q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [7:0] MK = (i == 0) ? 8'hFF : (i == 1) ? AUX_MASK : 8'h00;
        localparam logic [7:0] RV = ((i == 0) ? MAIN_RST : (i == 1) ? AUX_RST : 8'h00) & MK;
        if (i == ID_IDX) begin : g_id
            assign q[i] = id_code;
        end else if (MK == 8'h00) begin : g_ro
            assign q[i] = 8'h00;
        end else begin : g_rw
            logic [7:0] r;
            // Masked update on a strobe aimed at this register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    r <= RV;
                else if (wr_stb && wr_idx == 8'(i))
                    r <= (r & ~MK) | (wr_data & MK);
            end
            assign q[i] = r;
        end
    end

    // Read mux with zero fill above the bank.
    always_comb begin
        if (rd_idx < 8'(NREG))
            rd_data = q[rd_idx[IW-1:0]];
        else
            rd_data = 8'h00;
    end

    assign ctl_main = q[0];
    assign ctl_aux  = q[1];

endmodule

// File: rtl/smb_proto.sv
// Protocol engine: byte shifting, ack/nack decisions, offset pointer, byte
// count and read data sequencing for indexed block transfers.
// Assumes: conditioned edges; SDA changes by host only while SCL low.
module smb_proto
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6A,
    parameter int         NREG     = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_idx,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data
);
    localparam logic [7:0] SIZE_BYTE = 8'(NREG);

    phase_t     phase, nxt;
    logic [3:0] bitcnt;
    logic [7:0] shreg, txsh, ptr, remain;
    logic       in_ack;

    assign rd_idx = ptr;

    // Bus-event driven sequencer for receive, ack and transmit slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            nxt     <= PH_IDLE;
            bitcnt  <= 4'd0;
            shreg   <= 8'h00;
            txsh    <= 8'h00;
            ptr     <= 8'h00;
            remain  <= 8'h00;
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_idx  <= 8'h00;
            wr_data <= 8'h00;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                phase  <= PH_ADDR;
                bitcnt <= 4'd0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                phase  <= PH_IDLE;
                bitcnt <= 4'd0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (phase == PH_TX) begin
                if (scl_rise) begin
                    if (bitcnt < 4'd8) begin
                        bitcnt <= bitcnt + 4'd1;
                        txsh   <= {txsh[6:0], 1'b0};
                    end else if (!sda_lvl) begin
                        txsh   <= rd_data;
                        ptr    <= ptr + 8'd1;
                        bitcnt <= 4'd0;
                    end else begin
                        phase  <= PH_SKIP;
                    end
                end else if (scl_fall) begin
                    sda_oe <= (bitcnt < 4'd8) ? ~txsh[7] : 1'b0;
                end
            end else if (phase == PH_ADDR || phase == PH_OFFS ||
                         phase == PH_CNT  || phase == PH_WDATA) begin
                if (scl_rise && bitcnt < 4'd8) begin
                    shreg  <= {shreg[6:0], sda_lvl};
                    bitcnt <= bitcnt + 4'd1;
                end else if (scl_fall && bitcnt == 4'd8) begin
                    if (!in_ack) begin
                        in_ack <= 1'b1;
                        case (phase)
                            PH_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe <= 1'b1;
                                    nxt    <= shreg[0] ? PH_TX : PH_OFFS;
                                end else begin
                                    sda_oe <= 1'b0;
                                    nxt    <= PH_SKIP;
                                end
                            end
                            PH_OFFS: begin
                                sda_oe <= 1'b1;
                                ptr    <= shreg;
                                nxt    <= PH_CNT;
                            end
                            PH_CNT: begin
                                sda_oe <= 1'b1;
                                remain <= shreg;
                                nxt    <= PH_WDATA;
                            end
                            default: begin
                                if (remain != 8'h00) begin
                                    sda_oe  <= 1'b1;
                                    wr_stb  <= 1'b1;
                                    wr_idx  <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr + 8'd1;
                                    remain  <= remain - 8'd1;
                                    nxt     <= PH_WDATA;
                                end else begin
                                    sda_oe  <= 1'b0;
                                    nxt     <= PH_SKIP;
                                end
                            end
                        endcase
                    end else begin
                        in_ack <= 1'b0;
                        bitcnt <= 4'd0;
                        phase  <= nxt;
                        if (nxt == PH_TX) begin
                            txsh   <= SIZE_BYTE;
                            sda_oe <= ~SIZE_BYTE[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/smb_idx_slave.sv
// Top: indexed block-access serial register target. Conditions both bus
// lines, derives START/STOP, runs the protocol engine and the register bank.
// Assumes: no clock stretching, single host, pad handles open drain.
module smb_idx_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h6A,
    parameter int         NREG        = 7,
    parameter int         ID_IDX      = 6,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] MAIN_RST    = 8'h02,
    parameter logic [7:0] AUX_RST     = 8'h04,
    parameter logic [7:0] AUX_MASK    = 8'h04
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [7:0] id_code,
    output logic [7:0] ctl_main,
    output logic [7:0] ctl_aux,
    output logic       wr_stb,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data
);
    localparam int SCL = 0;
    localparam int SDA = 1;

    logic [1:0] raw_l, lvl_l, rise_l, fall_l;
    logic       scl_lvl, scl_rise, scl_fall, sda_lvl;
    logic       start_det, stop_det;
    logic [7:0] rd_idx, rd_data;

    assign raw_l = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        smb_deglitch #(.STAGES(SYNC_STAGES)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_l[g]),
            .level (lvl_l[g]),
            .rise  (rise_l[g]),
            .fall  (fall_l[g])
        );
    end

    assign scl_lvl   = lvl_l[SCL];
    assign scl_rise  = rise_l[SCL];
    assign scl_fall  = fall_l[SCL];
    assign sda_lvl   = lvl_l[SDA];
    assign start_det = fall_l[SDA] & scl_lvl;
    assign stop_det  = rise_l[SDA] & scl_lvl;

    smb_proto #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    smb_regbank #(
        .NREG(NREG), .ID_IDX(ID_IDX), .MAIN_RST(MAIN_RST),
        .AUX_RST(AUX_RST), .AUX_MASK(AUX_MASK)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .id_code  (id_code),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .ctl_main (ctl_main),
        .ctl_aux  (ctl_aux)
    );

endmodule

// File: rtl/smb_chk.sv
// Checker for smb_idx_slave: timing of SDA drive, strobes and register updates.
// Assumes: attached by the bind below.
module smb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [7:0] wr_idx,
    input logic [7:0] ctl_main,
    input logic [7:0] ctl_aux
);
    // SDA drive only moves after an SCL fall or a START/STOP release.
    p_oe_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // STOP leaves the line released.
    p_release_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // Strobe is a single-cycle pulse.
    p_pulse_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // Strobe only while SCL is low.
    p_stb_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !scl_lvl);

    // Register 0 changes only after a strobe aimed at it.
    p_main_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_main) |-> $past(wr_stb && wr_idx == 8'd0));

    // Register 1 changes only after a strobe aimed at it.
    p_aux_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_aux) |-> $past(wr_stb && wr_idx == 8'd1));

endmodule

bind smb_idx_slave smb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wr_idx    (wr_idx),
    .ctl_main  (ctl_main),
    .ctl_aux   (ctl_aux)
);

// File: tb/sim_smb_idx_slave.sv
module sim_smb_idx_slave;
    localparam int H = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_h = 1'b1;
    logic       glitch_on = 1'b0;
    logic [7:0] id_code = 8'h3C;
    logic       sda_oe, wr_stb;
    logic [7:0] ctl_main, ctl_aux, wr_idx, wr_data;
    wire        sda_line = sda_h & ~sda_oe;

    int nchk = 0, nerr = 0, unstable = 0, stb_n = 0;
    logic [7:0] last_idx = 8'h00, last_dat = 8'h00;
    logic done = 1'b0;

    always #10 clk = ~clk;

    smb_idx_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .id_code(id_code), .ctl_main(ctl_main),
        .ctl_aux(ctl_aux), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    always @(posedge clk) if (wr_stb) begin
        stb_n    <= stb_n + 1;
        last_idx <= wr_idx;
        last_dat <= wr_data;
    end

    // {offset, written, expected readback}
    localparam logic [23:0] VEC [8] = '{
        {8'h00, 8'hA5, 8'hA5}, {8'h00, 8'h5A, 8'h5A},
        {8'h01, 8'hFF, 8'h04}, {8'h01, 8'h00, 8'h00},
        {8'h02, 8'hFF, 8'h00}, {8'h06, 8'h00, 8'h3C},
        {8'h07, 8'h77, 8'h00}, {8'hFE, 8'h11, 8'h00}
    };

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    endtask

    task automatic h_start;
        wt(H/2); sda_h = 1'b1; wt(H/2); scl = 1'b1; wt(H);
        sda_h = 1'b0; wt(H); scl = 1'b0;
    endtask

    task automatic h_stop;
        wt(H/2); sda_h = 1'b0; wt(H/2); scl = 1'b1; wt(H);
        sda_h = 1'b1; wt(H);
    endtask

    task automatic h_bit_out(input logic b);
        wt(H/2); sda_h = b;
        if (glitch_on) begin
            wt(2); scl = 1'b1; wt(1); scl = 1'b0; wt(H/2 - 3);
        end else begin
            wt(H/2);
        end
        scl = 1'b1; wt(H); scl = 1'b0;
    endtask

    task automatic h_bit_in(output logic b);
        logic s1;
        wt(H/2); sda_h = 1'b1; wt(H/2); scl = 1'b1;
        wt(H/4); s1 = sda_line;
        wt(H/2); if (sda_line !== s1) unstable++;
        wt(H - H/4 - H/2); b = s1; scl = 1'b0;
    endtask

    task automatic h_wbyte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) h_bit_out(d[i]);
        h_bit_in(ack);
    endtask

    task automatic h_rbyte(input logic nack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin h_bit_in(b); d[i] = b; end
        h_bit_out(nack);
    endtask

    task automatic blk_write(input logic [7:0] off, input logic [7:0] cnt, input int nb,
                             input logic [31:0] dat, output logic [6:0] acks);
        logic a;
        acks = '0;
        h_start;
        h_wbyte(8'hD4, a); acks[0] = a;
        h_wbyte(off, a);   acks[1] = a;
        h_wbyte(cnt, a);   acks[2] = a;
        for (int k = 0; k < nb; k++) begin h_wbyte(dat[8*k +: 8], a); acks[3+k] = a; end
        h_stop;
    endtask

    task automatic blk_read(input logic [7:0] off, input int nb,
                            output logic [7:0] cb, output logic [31:0] d);
        logic a;
        logic [7:0] b;
        d = '0;
        h_start; h_wbyte(8'hD4, a); h_wbyte(off, a);
        h_start; h_wbyte(8'hD5, a);
        h_rbyte(1'b0, cb);
        for (int k = 0; k < nb; k++) begin h_rbyte(k == nb - 1, b); d[8*k +: 8] = b; end
        h_stop;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            report;
        end
    end

    initial begin
        logic [6:0]  acks;
        logic [7:0]  cb;
        logic [31:0] d;
        logic        a;
        int          s0;
        wt(5); rst_n = 1'b1; wt(5);
        chk("R6 sda released", 32'(sda_oe), 0);
        chk("R6 ctl_main reset", 32'(ctl_main), 32'h02);
        chk("R6 ctl_aux reset", 32'(ctl_aux), 32'h04);

        // Table: single-byte write then indexed read-back (R2 R4 R7 R8)
        for (int i = 0; i < 8; i++) begin
            blk_write(VEC[i][23:16], 8'd1, 1, {24'h0, VEC[i][15:8]}, acks);
            chk("R2 write acks", 32'(acks[3:0]), 0);
            blk_read(VEC[i][23:16], 1, cb, d);
            chk("R4 size byte", 32'(cb), 32'h07);
            chk("R7/R8 readback", d[7:0], 32'(VEC[i][7:0]));
        end
        chk("R2 ctl_main after table", 32'(ctl_main), 32'h5A);

        // Count limit and strobe port (R2 R3 R11)
        s0 = stb_n;
        blk_write(8'h00, 8'd2, 3, {8'h0, 8'h99, 8'h04, 8'h3C}, acks);
        chk("R3 extra byte nack", 32'(acks), 32'b0100000);
        chk("R2 ctl_main", 32'(ctl_main), 32'h3C);
        chk("R3 ctl_aux", 32'(ctl_aux), 32'h04);
        chk("R11 strobe count", 32'(stb_n - s0), 2);
        chk("R11 last idx", 32'(last_idx), 32'h01);
        chk("R11 last data", 32'(last_dat), 32'h04);

        // Multi-byte reads (R4 R5 R8)
        blk_read(8'h00, 3, cb, d);
        chk("R4 size byte", 32'(cb), 32'h07);
        chk("R4 burst data", d[23:0], 32'h00043C);
        wt(4);
        chk("R5 released after nack", 32'(sda_oe), 0);
        blk_read(8'h05, 3, cb, d);
        chk("R8 burst past end", d[23:0], 32'h003C00);

        // Foreign addresses (R1)
        h_start; h_wbyte(8'hA0, a); chk("R1 foreign addr nack", 32'(a), 1);
        h_wbyte(8'h00, a); chk("R1 stays released", 32'(a), 1);
        h_wbyte(8'hFF, a); chk("R1 stays released", 32'(a), 1);
        h_stop;
        h_start; h_wbyte(8'hD7, a); chk("R1 foreign read nack", 32'(a), 1);
        h_stop;
        chk("R1 no change", 32'(ctl_main), 32'h3C);

        // Abort by STOP mid-byte, then by START mid-transfer (R9)
        h_start; h_wbyte(8'hD4, a); h_wbyte(8'h00, a); h_wbyte(8'h01, a);
        for (int i = 0; i < 4; i++) h_bit_out(1'b1);
        h_stop;
        chk("R9 stop abort no write", 32'(ctl_main), 32'h3C);
        chk("R9 released", 32'(sda_oe), 0);
        h_start; h_wbyte(8'hD4, a); h_wbyte(8'h01, a);
        for (int i = 0; i < 3; i++) h_bit_out(1'b0);
        h_start; h_wbyte(8'hD4, a); chk("R9 restart addr ack", 32'(a), 0);
        h_wbyte(8'h00, a); h_wbyte(8'h01, a); h_wbyte(8'h22, a);
        h_stop;
        chk("R9 clean restart write", 32'(ctl_main), 32'h22);
        chk("R9 aux untouched", 32'(ctl_aux), 32'h04);

        // Single-cycle SCL glitch (R12)
        glitch_on = 1'b1;
        blk_write(8'h00, 8'd1, 1, 32'h81, acks);
        glitch_on = 1'b0;
        chk("R12 acks with glitch", 32'(acks[3:0]), 0);
        chk("R12 data with glitch", 32'(ctl_main), 32'h81);

        chk("R10 sda stable while scl high", 32'(unstable), 0);
        done = 1'b1;
        report;
    end
endmodule